// File: doc/BRIEF.md
# Multi-Rate Row Refresh Controller

This block paces per-row refresh of a DRAM device. Rows are not all refreshed at the worst-case rate. Each row is refreshed at a rate picked from the retention bin it belongs to. A slot timer splits time into equal slots, and one row is considered per slot, so refresh work is spread evenly and never arrives as a burst. A full walk over all rows is one base period of nominally 64 ms. A 2-bit phase counter, stepped at the end of each walk, selects which bins are due during that walk.

In the slot where a row is considered, the controller raises a one-cycle probe that carries the row address. Two external membership filters answer in the same cycle: one for the shortest-retention bin, one for the middle bin. The shortest matching bin decides. A row in neither bin falls into the longest period. A due row becomes a refresh request on a valid/ready handshake toward the command issuer, and is held there until it is taken. A row that is not due is passed over, but still uses up its slot. A false hit from either filter can only make a row be refreshed more often than it needs.

Top module: `mrr_refresh_ctrl`

## Requirements
- R1: After a synchronous reset, `req_valid` and `qry_valid` are 0 and `qry_row` is 0. The walk starts at row 0 in phase 0. The first probe occurs in the SLOT_CYCLES-th cycle after reset is released.
- R2: `qry_valid` pulses for one cycle per slot. The hit inputs are used only in a cycle with `qry_valid` high, and their values in any other cycle have no effect.
- R3: A row whose short-bin hit (`qry_hit_short`=1) is seen at its probe is requested in every walk (every phase).
- R4: A row with only the middle-bin hit is requested in phases 0 and 2 and passed over in phases 1 and 3.
- R5: A row with neither hit is requested only in phase 0, which is one walk in four.
- R6: A row that hits both filters is treated as a short-bin row (the shortest period wins).
- R7: Rows are probed in increasing address order, 0 to NUM_ROWS-1, and wrap to 0. Every wrap advances the phase by one, modulo 4.
- R8: While a request is pending, `req_valid` stays high and `req_row` stays stable until a cycle with `req_ready` high. The slot timer is paused and no probe is issued. `req_valid` is low in the cycle after acceptance.
- R9: The next probe comes exactly SLOT_CYCLES cycles after the acceptance edge of a request, or after the probe edge of a row that was passed over.
- R10: `req_row` equals the `qry_row` of the probe that produced the request, and `req_valid` rises in the cycle after that probe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| qry_valid | output | 1 | Probe strobe: the filter answers are sampled this cycle |
| qry_row | output | ROW_W | Row address presented to both filters |
| qry_hit_short | input | 1 | Row is in the shortest-retention bin (same-cycle answer) |
| qry_hit_mid | input | 1 | Row is in the middle-retention bin (same-cycle answer) |
| req_valid | output | 1 | A row refresh request is pending |
| req_row | output | ROW_W | Row to refresh |
| req_ready | input | 1 | Issuer takes the request when high together with `req_valid` |

## Verification
Two events can fall on the same cycle. One is the acceptance of the last row's request, which moves the walk to row 0 and advances the phase. The other is the phase-dependent decision for the next row. To provoke this, every request for row NUM_ROWS-1 is stalled for several cycles. Row 0 is placed in no bin, so it is due only when the phase has just wrapped to 0, and the last row is placed in the middle bin only, so its own decision depends on the old phase. The bench keeps its own model of the row and phase. It judges each probe by its row address, its distance in cycles from the previous acceptance or pass-over, and whether a request follows. A phase that is applied one row early or late shows up as a wrong request or a wrong pass-over at the boundary.

// File: rtl/mrr_pkg.sv
package mrr_pkg;

    // Number of walks in a full schedule; the 2-bit phase counts these.
    localparam int unsigned PHASES = 4;

    typedef logic [1:0] phase_t;

    typedef enum logic [1:0] {
        BIN_SHORT = 2'd0,
        BIN_MID   = 2'd1,
        BIN_LONG  = 2'd2
    } ret_bin_e;

    typedef struct packed {
        logic     due;
        ret_bin_e bin;
    } verdict_t;

    // Shortest matching bin wins; a false hit can only shorten the period.
    function automatic ret_bin_e classify(input logic hit_short, input logic hit_mid);
        ret_bin_e b;
        if (hit_short)    b = BIN_SHORT;
        else if (hit_mid) b = BIN_MID;
        else              b = BIN_LONG;
        return b;
    endfunction

    // Short: every walk. Mid: even phases. Long: phase 0 only.
    function automatic logic bin_due(input ret_bin_e b, input phase_t ph);
        logic d;
        case (b)
            BIN_SHORT: d = 1'b1;
            BIN_MID:   d = ~ph[0];
            default:   d = (ph == 2'd0);
        endcase
        return d;
    endfunction

endpackage

// File: rtl/mrr_slot_timer.sv
module mrr_slot_timer #(
    parameter int unsigned SLOT_CYCLES = 7812
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    output logic fire
);
    localparam int unsigned CW = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(SLOT_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    // The slot ends on the last count unless a request is still waiting.
    assign fire = !hold && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!hold) begin
            if (cnt_q == LAST) cnt_q <= '0;
            else               cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mrr_row_walker.sv
module mrr_row_walker
    import mrr_pkg::*;
#(
    parameter int unsigned NUM_ROWS = 8192,
    parameter int unsigned ROW_W    = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output logic [ROW_W-1:0] row_q,
    output phase_t           phase_q,
    output logic             wrap
);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(NUM_ROWS - 1);

    assign wrap = step && (row_q == LAST_ROW);

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q   <= '0;
            phase_q <= '0;
        end else if (step) begin
            if (row_q == LAST_ROW) begin
                row_q   <= '0;
                phase_q <= phase_q + 2'd1;
            end else begin
                row_q <= row_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/mrr_bin_decider.sv
module mrr_bin_decider
    import mrr_pkg::*;
(
    input  logic     hit_short,
    input  logic     hit_mid,
    input  phase_t   phase,
    output verdict_t verdict
);
    always_comb begin
        verdict.bin = classify(hit_short, hit_mid);
        verdict.due = bin_due(verdict.bin, phase);
    end
endmodule

// File: rtl/mrr_req_stage.sv
module mrr_req_stage #(
    parameter int unsigned ROW_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [ROW_W-1:0] load_row,
    input  logic             ready,
    output logic             valid_q,
    output logic [ROW_W-1:0] row_q,
    output logic             accept
);
    assign accept = valid_q && ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            row_q   <= '0;
        end else if (load) begin
            valid_q <= 1'b1;
            row_q   <= load_row;
        end else if (accept) begin
            valid_q <= 1'b0;
        end
    end
endmodule

// File: rtl/mrr_refresh_ctrl.sv
module mrr_refresh_ctrl
    import mrr_pkg::*;
#(
    parameter int unsigned NUM_ROWS    = 8192,
    parameter int unsigned SLOT_CYCLES = 7812,
    localparam int unsigned ROW_W      = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    output logic             qry_valid,
    output logic [ROW_W-1:0] qry_row,
    input  logic             qry_hit_short,
    input  logic             qry_hit_mid,
    output logic             req_valid,
    output logic [ROW_W-1:0] req_row,
    input  logic             req_ready
);
    logic             slot_fire;
    logic             walk_step;
    logic             walk_wrap;
    logic             req_accept;
    logic             req_load;
    logic [ROW_W-1:0] cur_row;
    phase_t           phase_q;
    verdict_t         verdict;

    mrr_slot_timer #(.SLOT_CYCLES(SLOT_CYCLES)) timer_i (
        .clk  (clk),
        .rst  (rst),
        .hold (req_valid),
        .fire (slot_fire)
    );

    mrr_row_walker #(.NUM_ROWS(NUM_ROWS), .ROW_W(ROW_W)) walker_i (
        .clk     (clk),
        .rst     (rst),
        .step    (walk_step),
        .row_q   (cur_row),
        .phase_q (phase_q),
        .wrap    (walk_wrap)
    );

    mrr_bin_decider decider_i (
        .hit_short (qry_hit_short),
        .hit_mid   (qry_hit_mid),
        .phase     (phase_q),
        .verdict   (verdict)
    );

    mrr_req_stage #(.ROW_W(ROW_W)) req_i (
        .clk      (clk),
        .rst      (rst),
        .load     (req_load),
        .load_row (cur_row),
        .ready    (req_ready),
        .valid_q  (req_valid),
        .row_q    (req_row),
        .accept   (req_accept)
    );

    assign qry_valid = slot_fire;
    assign qry_row   = cur_row;
    assign req_load  = slot_fire && verdict.due;
    // Advance past a row either when it is skipped or once its refresh is taken.
    assign walk_step = (slot_fire && !verdict.due) || req_accept;
endmodule

// File: rtl/mrr_refresh_ctrl_chk.sv
module mrr_refresh_ctrl_chk #(
    parameter int unsigned NUM_ROWS    = 8192,
    parameter int unsigned SLOT_CYCLES = 7812,
    localparam int unsigned ROW_W      = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
    input logic             clk,
    input logic             rst,
    input logic             qry_valid,
    input logic [ROW_W-1:0] qry_row,
    input logic             qry_hit_short,
    input logic             qry_hit_mid,
    input logic             req_valid,
    input logic [ROW_W-1:0] req_row,
    input logic             req_ready,
    input logic [1:0]       phase_q,
    input logic             walk_wrap
);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(NUM_ROWS - 1);

    // R8
    a_r8_hold_until_ready: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready |=> req_valid && $stable(req_row));

    // R8
    a_r8_no_probe_while_pending: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> !qry_valid);

    // R3, R6, R10
    a_r3_short_requested: assert property (@(posedge clk) disable iff (rst)
        qry_valid && qry_hit_short |=> req_valid && (req_row == $past(qry_row)));

    // R4
    a_r4_mid_odd_skipped: assert property (@(posedge clk) disable iff (rst)
        qry_valid && !qry_hit_short && qry_hit_mid && phase_q[0] |=> !req_valid);

    // R5
    a_r5_long_skipped: assert property (@(posedge clk) disable iff (rst)
        qry_valid && !qry_hit_short && !qry_hit_mid && (phase_q != 2'd0) |=> !req_valid);

    // R7
    a_r7_next_row_after_accept: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=>
            qry_row == (($past(req_row) == LAST_ROW) ? '0 : $past(req_row) + 1'b1));

    // R7
    a_r7_phase_steps_on_wrap: assert property (@(posedge clk) disable iff (rst)
        walk_wrap |=> phase_q == $past(phase_q) + 2'd1);

    // R2
    a_r2_single_probe_per_slot: assert property (@(posedge clk) disable iff (rst)
        qry_valid && (SLOT_CYCLES > 1) |=> !qry_valid);
endmodule

bind mrr_refresh_ctrl mrr_refresh_ctrl_chk #(
    .NUM_ROWS    (NUM_ROWS),
    .SLOT_CYCLES (SLOT_CYCLES)
) chk_i (
    .clk           (clk),
    .rst           (rst),
    .qry_valid     (qry_valid),
    .qry_row       (qry_row),
    .qry_hit_short (qry_hit_short),
    .qry_hit_mid   (qry_hit_mid),
    .req_valid     (req_valid),
    .req_row       (req_row),
    .req_ready     (req_ready),
    .phase_q       (phase_q),
    .walk_wrap     (walk_wrap)
);

// File: tb/mrr_refresh_ctrl_tb_top.sv
`timescale 1ns/1ps
module mrr_refresh_ctrl_tb_top;
    localparam int ROWS   = 12;
    localparam int SLOT   = 3;
    localparam int RW     = $clog2(ROWS);
    localparam int SWEEPS = 9;
    localparam int LIMIT  = 20000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          qry_valid;
    logic [RW-1:0] qry_row;
    logic          qry_hit_short;
    logic          qry_hit_mid;
    logic          req_valid;
    logic [RW-1:0] req_row;
    logic          req_ready = 1'b0;

    logic junk_s = 1'b0;
    logic junk_m = 1'b0;
    logic in_short [ROWS];
    logic in_mid   [ROWS];

    int checks = 0;
    int fails  = 0;
    int edge_n = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) edge_n++;

    mrr_refresh_ctrl #(.NUM_ROWS(ROWS), .SLOT_CYCLES(SLOT)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .qry_valid     (qry_valid),
        .qry_row       (qry_row),
        .qry_hit_short (qry_hit_short),
        .qry_hit_mid   (qry_hit_mid),
        .req_valid     (req_valid),
        .req_row       (req_row),
        .req_ready     (req_ready)
    );

    // Filter model: true answers during a probe, random junk otherwise (R2).
    always_comb begin
        qry_hit_short = junk_s;
        qry_hit_mid   = junk_m;
        if (qry_valid && int'(qry_row) < ROWS) begin
            qry_hit_short = in_short[int'(qry_row)];
            qry_hit_mid   = in_mid[int'(qry_row)];
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic bit exp_due(input int row, input int ph);
        if (in_short[row]) return 1'b1;
        if (in_mid[row])   return (ph % 2) == 0;
        return ph == 0;
    endfunction

    function automatic string bin_tag(input int row);
        if (in_short[row] && in_mid[row]) return "R6";
        if (in_short[row])                return "R3";
        if (in_mid[row])                  return "R4";
        return "R5";
    endfunction

    initial begin
        int      mrow = 0;
        int      mph = 0;
        int      sweeps = 0;
        int      ref_edge = 0;
        int      stall_left = 0;
        int      exp_row = 0;
        bit      chk_pending = 0;
        bit      want_req = 0;
        bit      prev_valid = 0;
        bit      prev_ready = 0;
        bit      prev_hs = 0;
        int      prev_row = 0;
        int unsigned seed_val;

        seed_val = $urandom(32'd20251);
        for (int i = 0; i < ROWS; i++) begin
            in_short[i] = ($urandom % 4) == 0;
            in_mid[i]   = ($urandom % 3) == 0;
        end
        // Directed corners: row 0 long-only, last row mid-only, overlap rows.
        in_short[0] = 1'b0;        in_mid[0] = 1'b0;
        in_short[ROWS-1] = 1'b0;   in_mid[ROWS-1] = 1'b1;
        in_short[5] = 1'b1;        in_mid[5] = 1'b1;
        in_short[3] = 1'b1;        in_mid[3] = 1'b0;
        in_short[7] = 1'b0;        in_mid[7] = 1'b0;

        repeat (4) @(posedge clk);
        @(negedge clk);
        check(!req_valid, "R1", "req_valid in reset", int'(req_valid), 0);
        check(!qry_valid, "R1", "qry_valid in reset", int'(qry_valid), 0);
        check(qry_row == '0, "R1", "qry_row in reset", int'(qry_row), 0);
        rst = 1'b0;
        ref_edge = edge_n;

        while (sweeps < SWEEPS && edge_n < LIMIT) begin
            @(negedge clk);

            if (prev_hs) begin
                check(!req_valid, "R8", "req_valid after accept", int'(req_valid), 0);
                ref_edge = edge_n;
            end

            if (chk_pending) begin
                chk_pending = 0;
                if (want_req) begin
                    check(req_valid && int'(req_row) == exp_row,
                          {bin_tag(exp_row), "/R10"}, "requested row",
                          req_valid ? int'(req_row) : -1, exp_row);
                    stall_left = (exp_row == ROWS - 1) ? 7 : int'($urandom % 4);
                end else begin
                    check(!req_valid, bin_tag(exp_row), "row passed over",
                          int'(req_valid), 0);
                end
            end else if (prev_valid && !prev_ready) begin
                check(req_valid && int'(req_row) == prev_row, "R8", "held request row",
                      req_valid ? int'(req_row) : -1, prev_row);
            end

            if (qry_valid) begin
                check(!req_valid, "R8", "probe while pending", int'(req_valid), 0);
                check(int'(qry_row) == mrow, "R7", "probe row order", int'(qry_row), mrow);
                check(edge_n - ref_edge == SLOT - 1, "R9", "probe spacing",
                      edge_n - ref_edge, SLOT - 1);
                want_req    = exp_due(mrow, mph);
                exp_row     = mrow;
                chk_pending = 1;
                if (!want_req) ref_edge = edge_n + 1;
                if (mrow == ROWS - 1) begin
                    mrow = 0;
                    mph  = (mph + 1) % 4;
                    sweeps++;
                end else begin
                    mrow++;
                end
            end

            if (req_valid) begin
                if (stall_left > 0) begin
                    req_ready  = 1'b0;
                    stall_left--;
                end else begin
                    req_ready = 1'b1;
                end
            end else begin
                req_ready = 1'($urandom % 2);
            end
            junk_s = 1'($urandom % 2);
            junk_m = 1'($urandom % 2);

            prev_valid = req_valid;
            prev_ready = req_ready;
            prev_row   = int'(req_row);
            prev_hs    = req_valid && req_ready;
        end

        if (sweeps < SWEEPS) begin
            checks++;
            fails++;
            $display("FAIL R2 watchdog: walks completed actual=%0d expected=%0d", sweeps, SWEEPS);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule